// File: doc/BRIEF.md
# Power Domain Power-Up Sequencer

This block brings a switchable logic island, such as a vector coprocessor domain, out of power-down under hardware control. A one-cycle start pulse launches a fixed sequence. The block releases the domain's reset and then raises a power-on request. It polls for an acknowledge from the power switch and, after a settle gap, raises a power-good request. It then polls for a second acknowledge. After further settle gaps it releases the isolation clamp and finally returns the reset control to its final level.

Polling is bounded. If either acknowledge does not arrive within a fixed number of spaced samples, the sequence stops where it is and raises an error flag. Timing is set by the `CLK_HZ` parameter. One polling interval is a whole number of cycles covering at least 1 µs. One settle gap covers at least 500 ns. Both acknowledge inputs come from another power domain, so each one passes through a two-flop synchronizer before it is used.

Top module: `pwr_domain_seq`

## Requirements
- R1: A start pulse accepted in idle, done or error drives `dom_rst_o` to 0, `clamp_o` to 1, both requests to 0 and both flags to 0 on the next edge. `on_req_o` rises one edge after that.
- R2: `on_ack_i` is synchronized by two flops. It is then sampled first one cycle after `on_req_o` rises, then every U cycles, for at most 10 samples.
- R3: If none of the 10 power-on samples sees the acknowledge, `err_o` rises at the tenth sample. After that, no request, clamp or reset output changes until the next start.
- R4: `good_req_o` rises H cycles after the sample that accepted the power-on acknowledge.
- R5: `good_ack_i` is synchronized and polled the same way as `on_ack_i`. Exhausting its 10 samples raises `err_o` with the clamp still asserted.
- R6: `clamp_o` falls H cycles after the power-good acknowledge is accepted. H cycles after that, `dom_rst_o` returns to 1 and `done_o` rises in the same cycle.
- R7: A start pulse during a running sequence is ignored.
- R8: `done_o` and `err_o` are never high together. Each stays set until the next accepted start.
- R9: U = ceil(CLK_HZ / 1e6) and H = ceil(CLK_HZ / 2e6) cycles.
- R10: While `rst_n` is low at a clock edge, the block returns to idle: `clamp_o`=1, `dom_rst_o`=1, both requests 0 and both flags 0.
- R11: `state_o` encodes 0 idle, 1 reset release, 2 power-on polling, 3 power-on settle, 4 power-good polling, 5 power-good settle, 6 clamp settle, 7 done, 8 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| on_ack_i | input | 1 | Power-on acknowledge, asynchronous |
| good_ack_i | input | 1 | Power-good acknowledge, asynchronous |
| dom_rst_o | output | 1 | Domain reset control (0 = released) |
| on_req_o | output | 1 | Power-on request |
| good_req_o | output | 1 | Power-good request |
| clamp_o | output | 1 | Isolation clamp (1 = clamped) |
| done_o | output | 1 | Sequence completed, sticky |
| err_o | output | 1 | Acknowledge timeout, sticky |
| state_o | output | 4 | Current step code |

## Verification
A wrong poll counter or timer shows up at the ports as a shift in the cycle where `good_req_o`, `clamp_o` or `done_o` changes, or where `err_o` rises. That shift is visible within one polling interval of the faulty sample. An ordering fault in the state machine breaks the fixed relation between the outputs as soon as the wrong step is taken. For example, the clamp could drop while `good_req_o` is low, or a request could rise while the reset is still held. The acknowledge delays are placed just before and just after the tenth sample so that an off-by-one in the retry limit appears as a timeout that should not happen, or as one that is missed.

// File: rtl/pwr_domain_seq.sv
`timescale 1ns/1ps
module pwr_domain_seq #(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned MAX_TRIES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       on_ack_i,
  input  logic       good_ack_i,
  output logic       dom_rst_o,
  output logic       on_req_o,
  output logic       good_req_o,
  output logic       clamp_o,
  output logic       done_o,
  output logic       err_o,
  output logic [3:0] state_o
);
  localparam int unsigned US_CYC   = (CLK_HZ + 999_999) / 1_000_000;
  localparam int unsigned HALF_CYC = (CLK_HZ + 1_999_999) / 2_000_000;
  localparam int TW  = $clog2(US_CYC + 1);
  localparam int TRW = $clog2(MAX_TRIES + 1);

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0, ST_REL = 4'd1, ST_ON_POLL = 4'd2, ST_ON_SET = 4'd3,
    ST_GD_POLL = 4'd4, ST_GD_SET = 4'd5, ST_CLMP_SET = 4'd6,
    ST_DONE = 4'd7, ST_ERR = 4'd8
  } st_t;

  st_t          st;
  logic [TW-1:0]  tmr;
  logic [TRW-1:0] tries;
  logic [1:0]     on_sy, gd_sy;

  wire tmr_zero = (tmr == '0);
  wire last_try = (tries == TRW'(MAX_TRIES - 1));
  wire poll_ack = (st == ST_ON_POLL) ? on_sy[1] : gd_sy[1];

  assign state_o = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_sy <= '0;
      gd_sy <= '0;
    end else begin
      on_sy <= {on_sy[0], on_ack_i};
      gd_sy <= {gd_sy[0], good_ack_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      tries      <= '0;
      dom_rst_o  <= 1'b1;
      on_req_o   <= 1'b0;
      good_req_o <= 1'b0;
      clamp_o    <= 1'b1;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE, ST_ERR: if (start_i) begin
          st         <= ST_REL;
          dom_rst_o  <= 1'b0;
          on_req_o   <= 1'b0;
          good_req_o <= 1'b0;
          clamp_o    <= 1'b1;
          done_o     <= 1'b0;
          err_o      <= 1'b0;
        end
        ST_REL: begin
          on_req_o <= 1'b1;
          tmr      <= '0;
          tries    <= '0;
          st       <= ST_ON_POLL;
        end
        ST_ON_POLL, ST_GD_POLL: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (poll_ack) begin
            st  <= (st == ST_ON_POLL) ? ST_ON_SET : ST_GD_SET;
            tmr <= TW'(HALF_CYC - 1);
          end else if (last_try) begin
            st    <= ST_ERR;
            err_o <= 1'b1;
          end else begin
            tries <= tries + 1'b1;
            tmr   <= TW'(US_CYC - 1);
          end
        end
        ST_ON_SET: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else begin
            good_req_o <= 1'b1;
            tmr        <= '0;
            tries      <= '0;
            st         <= ST_GD_POLL;
          end
        end
        ST_GD_SET: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else begin
            clamp_o <= 1'b0;
            tmr     <= TW'(HALF_CYC - 1);
            st      <= ST_CLMP_SET;
          end
        end
        ST_CLMP_SET: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else begin
            dom_rst_o <= 1'b1;
            done_o    <= 1'b1;
            st        <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module pwr_domain_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       dom_rst_o,
  input logic       on_req_o,
  input logic       good_req_o,
  input logic       clamp_o,
  input logic       done_o,
  input logic       err_o,
  input logic [3:0] state_o
);
  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (clamp_o && dom_rst_o && !on_req_o && !good_req_o && !done_o && !err_o));

  // R1
  req_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_req_o) |-> !dom_rst_o);

  // R4
  good_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_req_o |-> on_req_o);

  // R6
  clamp_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_o |-> good_req_o);

  // R3
  err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> $stable({on_req_o, good_req_o, clamp_o, dom_rst_o}));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_o >= 4'd1 && state_o <= 4'd6) |=> (state_o != 4'd1));
endmodule

bind pwr_domain_seq pwr_domain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dom_rst_o(dom_rst_o),
  .on_req_o(on_req_o), .good_req_o(good_req_o), .clamp_o(clamp_o),
  .done_o(done_o), .err_o(err_o), .state_o(state_o)
);

// File: tb/pwr_domain_seq_bench.sv
`timescale 1ns/1ps
module pwr_domain_seq_bench;
  localparam int unsigned HZ = 199_900_000;
  localparam int U  = (HZ + 999_999) / 1_000_000;
  localparam int H  = (HZ + 1_999_999) / 2_000_000;
  localparam int NT = 10;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, on_ack_i = 1'b0, good_ack_i = 1'b0;
  logic dom_rst_o, on_req_o, good_req_o, clamp_o, done_o, err_o;
  logic [3:0] state_o;
  int checks = 0, failures = 0, cyc = 0;

  pwr_domain_seq #(.CLK_HZ(HZ), .MAX_TRIES(NT)) u_pwr_domain_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .on_ack_i(on_ack_i),
    .good_ack_i(good_ack_i), .dom_rst_o(dom_rst_o), .on_req_o(on_req_o),
    .good_req_o(good_req_o), .clamp_o(clamp_o), .done_o(done_o),
    .err_o(err_o), .state_o(state_o));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190_000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int sample_idx(input int d);
    return (d + 2 + U - 1) / U;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idle_vec();
    return {27'd0, dom_rst_o, on_req_o, good_req_o, clamp_o, done_o | err_o};
  endfunction

  task automatic run_seq(input int d1, input int d2);
    int tg = -1, tc = -1, td = -1, te = -1, n1, n2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R1: reset released, clamp held, requests and flags cleared
    chk(idle_vec() == 5'b00010, "R1", idle_vec(), 5'b00010);
    @(negedge clk);
    chk(on_req_o == 1'b1, "R1", on_req_o, 1);
    for (int c = 0; c < 6000; c++) begin
      if (c > 0) @(negedge clk);
      if (tg < 0 && good_req_o) tg = c;
      if (tc < 0 && !clamp_o)   tc = c;
      if (td < 0 && done_o)     td = c;
      if (te < 0 && err_o)      te = c;
      if (c == 4) chk(state_o == 4'd2, "R7", state_o, 2);
      if (td >= 0 || te >= 0) break;
      if (c == d1) on_ack_i = 1'b1;
      if (tg >= 0 && c == tg + d2) good_ack_i = 1'b1;
      start_i = (c == 3);
    end
    start_i = 1'b0;
    n1 = sample_idx(d1);
    if (n1 >= NT) begin
      chk(te == 1 + (NT - 1) * U, "R3", te, 1 + (NT - 1) * U);
      chk(tg == -1, "R3", tg, -1);
    end else begin
      chk(tg == 1 + n1 * U + H, "R2,R4,R9", tg, 1 + n1 * U + H);
      n2 = sample_idx(d2);
      if (n2 >= NT) begin
        chk(te == tg + 1 + (NT - 1) * U, "R5", te, tg + 1 + (NT - 1) * U);
        chk(tc == -1, "R5", tc, -1);
      end else begin
        chk(tc == tg + 1 + n2 * U + H, "R6", tc, tg + 1 + n2 * U + H);
        chk(td == tc + H, "R6", td, tc + H);
        chk(dom_rst_o == 1'b1, "R6", dom_rst_o, 1);
      end
    end
    repeat (20) @(negedge clk);
    chk((done_o ^ err_o) == 1'b1, "R8", {done_o, err_o}, (te >= 0) ? 1 : 2);
    chk(state_o == ((te >= 0) ? 4'd8 : 4'd7), "R11", state_o, (te >= 0) ? 8 : 7);
    on_ack_i = 1'b0;
    good_ack_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(idle_vec() == 5'b10010, "R10", idle_vec(), 5'b10010);
    chk(state_o == 4'd0, "R11", state_o, 0);
    @(negedge clk);
    run_seq(0, 0);
    run_seq(1798, 1798);
    run_seq(1799, 0);
    run_seq(400, 1799);
    run_seq(U - 2, U - 1);
    for (int i = 0; i < 10; i++)
      run_seq(int'($urandom_range(0, 2000)), int'($urandom_range(0, 2000)));
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R10 mid-sequence reset
    chk(idle_vec() == 5'b10010, "R10", idle_vec(), 5'b10010);
    chk(state_o == 4'd0, "R10", state_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule